// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a 32-pin bank of already-synchronised general purpose inputs and turns selected pin activity into interrupt events. Each pin can be set up separately to react to a level (high or low), to one edge (rising or falling), or to both edges. Every detected event is held in a sticky per-pin status bit until software clears it by writing a one to that bit.

A per-pin mask decides which status bits reach the single combined interrupt line. The mask cannot be written directly. One write-one port removes mask bits and another write-one port adds them, and the current mask can be read back at a separate address. Detection does not stop while a pin is masked, so an event seen during that time is still pending when the pin is unmasked. Software normally clears a pin's status before unmasking it, to avoid receiving a stale event.

The register interface is a plain single-cycle bus: a write strobe, a byte address and write data, with read data returned combinationally from the address.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every mask bit is 1, the status, edge-select, polarity and both-edge registers are 0, and `irq_out` is 0.
- R2: A pin whose edge-select bit (offset 0x00) is 0 is level sensitive: polarity bit 1 reacts to a high pin and 0 to a low pin. The status bit is set again on every cycle the active level is present, so a clear only sticks once the level has gone.
- R3: A pin whose edge-select bit is 1 and whose both-edge bit is 0 is edge sensitive: polarity bit (offset 0x04) 1 reacts to a 0-to-1 change and 0 to a 1-to-0 change, each measured against the pin value sampled on the previous cycle (0 out of reset).
- R4: When the both-edge bit (offset 0x08) of an edge-sensitive pin is 1, either change sets status and polarity is ignored. For a level-sensitive pin the both-edge bit has no effect.
- R5: A write to the unmask port (offset 0x0C) clears each mask bit whose data bit is 1 and leaves the rest unchanged.
- R6: A write to the mask-set port (offset 0x10) sets each mask bit whose data bit is 1 and leaves the rest unchanged.
- R7: The mask reads back at offset 0x14, where 1 means masked. A write to 0x14 leaves the mask unchanged.
- R8: Status (read at offset 0x18) is sticky. A write to 0x18 clears each status bit whose data bit is 1, and zero data bits have no effect.
- R9: Events are detected and latched whether or not the pin is masked. A latched event reaches `irq_out` once its mask bit is cleared.
- R10: `irq_out` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R11: If a new event and a clear write hit the same status bit in the same cycle, the bit stays set.
- R12: Edge-select, polarity and both-edge read back at their own offsets. The two write-one ports (0x0C, 0x10) and any unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPINS | Synchronised pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for `reg_addr`, combinational |
| evt_status | output | NPINS | Sticky per-pin event status |
| irq_out | output | 1 | Combined unmasked interrupt |

## Verification
A pin level or write presented in one cycle is captured at the next rising edge. Its effect on `evt_status`, the mask and `irq_out` is therefore visible one cycle later, and `irq_out` adds no further delay because it is decoded from those registers. Read data follows `reg_addr` in the same cycle. The bench drives inputs on the falling edge, advances its own reference model at the rising edge, and compares status and interrupt at the following falling edge. It compares read data shortly after driving the address, before the next rising edge.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic [NPINS-1:0]  evt_status,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_UNMSK = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_MVIEW = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(5'h18);

  logic [NPINS-1:0] edge_r, pol_r, both_r, mask_r, stat_r, pin_q;
  logic [NPINS-1:0] rise, fall, edge_hit, lvl_hit, hit, clr;

  assign rise     = pin_in & ~pin_q;
  assign fall     = ~pin_in & pin_q;
  assign edge_hit = (both_r & (rise | fall)) | (~both_r & ((pol_r & rise) | (~pol_r & fall)));
  assign lvl_hit  = (pol_r & pin_in) | (~pol_r & ~pin_in);
  assign hit      = (edge_r & edge_hit) | (~edge_r & lvl_hit);
  assign clr      = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_r <= '0;
      pol_r  <= '0;
      both_r <= '0;
      mask_r <= '1;
      stat_r <= '0;
      pin_q  <= '0;
    end else begin
      pin_q  <= pin_in;
      stat_r <= (stat_r & ~clr) | hit;
      if (reg_wr) begin
        case (reg_addr)
          A_EDGE:  edge_r <= reg_wdata;
          A_POL:   pol_r  <= reg_wdata;
          A_BOTH:  both_r <= reg_wdata;
          A_UNMSK: mask_r <= mask_r & ~reg_wdata;
          A_MSET:  mask_r <= mask_r | reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_EDGE:  reg_rdata = edge_r;
      A_POL:   reg_rdata = pol_r;
      A_BOTH:  reg_rdata = both_r;
      A_MVIEW: reg_rdata = mask_r;
      A_STAT:  reg_rdata = stat_r;
      default: reg_rdata = '0;
    endcase
  end

  assign evt_status = stat_r;
  assign irq_out    = |(stat_r & ~mask_r);

  assert_unmask_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_UNMSK) |=> ((mask_r & $past(reg_wdata)) == '0));

  assert_mask_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MSET) |=> ((mask_r & $past(reg_wdata)) == $past(reg_wdata)));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == A_UNMSK || reg_addr == A_MSET)) |=> $stable(mask_r));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STAT) |=> ((stat_r & $past(stat_r)) == $past(stat_r)));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT) |=> ((stat_r & $past(hit)) == $past(hit)));

  assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_r) |-> !irq_out);

  assert_unmasked_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_r != '0 && mask_r == '0) |-> irq_out);

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = 32'hFFFF_FFFE;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = 5'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, evt_status;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_edge = '0, m_pol = '0, m_both = '0, m_mask = '1, m_st = '0, m_prev = '0;
  logic [31:0] p;

  always #2 clk = ~clk;

  gpio_irq_unit #(.NPINS(32), .ADDR_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_status(evt_status), .irq_out(irq_out)
  );

  function automatic logic [31:0] exp_hit(logic [31:0] pins);
    logic [31:0] h;
    for (int i = 0; i < 32; i++) begin
      if (!m_edge[i])     h[i] = m_pol[i] ? pins[i] : !pins[i];
      else if (m_both[i]) h[i] = pins[i] != m_prev[i];
      else if (m_pol[i])  h[i] = pins[i] && !m_prev[i];
      else                h[i] = !pins[i] && m_prev[i];
    end
    return h;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a)
      5'h00: return m_edge;
      5'h04: return m_pol;
      5'h08: return m_both;
      5'h14: return m_mask;
      5'h18: return m_st;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [31:0] pins, input logic we, input logic [4:0] a,
                      input logic [31:0] d);
    logic [31:0] h, nst, nmask, nedge, npol, nboth;
    chk("R8 status", evt_status, m_st);
    chk("R10 irq", {31'b0, irq_out}, {31'b0, |(m_st & ~m_mask)});
    pin_in = pins; reg_wr = we; reg_addr = a; reg_wdata = d;
    #1;
    if (!we) chk((a == 5'h14) ? "R7 mask read" : "R12 read", reg_rdata, exp_read(a));
    h = exp_hit(pins);
    nst = m_st; nmask = m_mask; nedge = m_edge; npol = m_pol; nboth = m_both;
    if (we) begin
      case (a)
        5'h00: nedge = d;
        5'h04: npol = d;
        5'h08: nboth = d;
        5'h0C: nmask = m_mask & ~d;
        5'h10: nmask = m_mask | d;
        5'h18: nst = m_st & ~d;
        default: ;
      endcase
    end
    nst = nst | h;
    @(posedge clk);
    m_st = nst; m_mask = nmask; m_edge = nedge; m_pol = npol; m_both = nboth; m_prev = pins;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    reg_wr = 1'b0; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B_3C4D));
    p = 32'hFFFF_FFFE;
    repeat (3) @(negedge clk);
    chk("R1 reset status", evt_status, 32'h0);
    chk("R1 reset irq", {31'b0, irq_out}, 32'h0);
    rd_chk("R1 reset mask", 5'h14, 32'hFFFF_FFFF);
    rd_chk("R1 reset edge-select", 5'h00, 32'h0);
    rd_chk("R1 reset both-edge", 5'h08, 32'h0);
    rst_n = 1'b1;

    step(p, 1'b1, 5'h00, 32'h0000_003C);
    step(p, 1'b1, 5'h04, 32'h0000_0015);
    step(p, 1'b1, 5'h08, 32'h0000_0070);
    step(p, 1'b1, 5'h18, 32'hFFFF_FFFF);
    chk("R8 cleared", evt_status, 32'h0);

    p = p & ~32'h4; step(p, 1'b0, 5'h18, 0);
    chk("R3 falling on rising pin", {31'b0, evt_status[2]}, 32'h0);
    p = p | 32'h4; step(p, 1'b0, 5'h18, 0);
    chk("R3 rising pin", {31'b0, evt_status[2]}, 32'h1);
    p = p & ~32'h8; step(p, 1'b0, 5'h18, 0);
    chk("R3 falling pin", {31'b0, evt_status[3]}, 32'h1);

    p = p & ~32'h10; step(p, 1'b0, 5'h18, 0);
    chk("R4 both-edge fall", {31'b0, evt_status[4]}, 32'h1);
    step(p, 1'b1, 5'h18, 32'h10);
    chk("R8 clear one bit", evt_status & 32'h1C, 32'h0C);
    p = p | 32'h10; step(p, 1'b0, 5'h18, 0);
    chk("R4 both-edge rise", {31'b0, evt_status[4]}, 32'h1);
    chk("R4 level ignores both-edge", {31'b0, evt_status[6]}, 32'h0);

    p = p | 32'h1; step(p, 1'b0, 5'h18, 0);
    chk("R2 level high", {31'b0, evt_status[0]}, 32'h1);
    step(p, 1'b1, 5'h18, 32'h1);
    chk("R2 clear while active", {31'b0, evt_status[0]}, 32'h1);
    p = p & ~32'h1; step(p, 1'b0, 5'h18, 0);
    step(p, 1'b1, 5'h18, 32'h1);
    chk("R2 clear after level gone", {31'b0, evt_status[0]}, 32'h0);

    chk("R9 masked pending quiet", {31'b0, irq_out}, 32'h0);
    step(p, 1'b1, 5'h0C, 32'h8);
    chk("R9 unmask shows latched event", {31'b0, irq_out}, 32'h1);
    rd_chk("R5 unmask one bit", 5'h14, 32'hFFFF_FFF7);
    step(p, 1'b1, 5'h10, 32'h8);
    chk("R10 remasked", {31'b0, irq_out}, 32'h0);
    rd_chk("R6 mask set", 5'h14, 32'hFFFF_FFFF);
    step(p, 1'b1, 5'h14, 32'h0);
    rd_chk("R7 view write ignored", 5'h14, 32'hFFFF_FFFF);

    step(p, 1'b1, 5'h18, 32'h4);
    p = p & ~32'h4; step(p, 1'b0, 5'h18, 0);
    p = p | 32'h4; step(p, 1'b1, 5'h18, 32'h4);
    chk("R11 event beats clear", {31'b0, evt_status[2]}, 32'h1);

    rd_chk("R12 edge-select readback", 5'h00, 32'h3C);
    rd_chk("R12 unmask port reads zero", 5'h0C, 32'h0);
    rd_chk("R12 unmapped reads zero", 5'h1C, 32'h0);

    for (int k = 0; k < 4000; k++) begin
      logic [4:0] a;
      logic we;
      logic [31:0] d;
      p = p ^ ($urandom & $urandom & $urandom);
      a = 5'(($urandom % 8) * 4);
      we = ($urandom % 3) == 0;
      d = $urandom;
      if (($urandom % 2) == 0) d = d & $urandom;
      step(p, we, a, d);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule